// File: doc/BRIEF.md
# Single-Wire Pulse-Width Bus Slave

This block is the device end of a shared, open-drain control line that idles high and is driven low by a host. The host encodes every symbol as the length of one low pulse, and the block measures each pulse against its own clock. A short pulse is a zero, or a prompt while a read is open. A medium pulse is a one. A long pulse is a frame marker. From this symbol stream the block follows the command framing. It takes an identity once, selects itself when an address matches, loads a control register of 8, 16 or 24 bits, and during reads answers prompts by pulling the line low for zero bits.

All time limits are given in microseconds and scaled by the `CYC_PER_US` parameter. `SLICES` sets the register width to 8 bits per slice. An enable input takes the place of the external ordering timer that decides when a device may accept its identity. The control register and the assigned identity are outputs, so the rest of the chip can use them.

Top module: `swbus_slave`

## Requirements
- R1: The block measures each low pulse. A width of 1 to 8 µs is a zero or a prompt, 24 to 36 µs is a one, and 80 to 120 µs is a marker. Any other width is invalid.
- R2: A marker followed by three bits forms a command. Bits are listed in the order sent: 010 selects by address, 011 assigns identity, 001 writes, 000 broadcasts, 101 reads, and 111 closes the sequence.
- R3: An address command carries 4 bits, least significant first. The device becomes selected only if it holds an assigned identity equal to those bits. A write or read issued while the device is not selected has no effect.
- R4: Write and broadcast data arrive least significant bit first. They take effect at the next marker only if at least the register width in bits was received, and only the last register-width bits are kept.
- R5: A broadcast loads the register whether or not the device is selected.
- R6: The identity command takes 4 bits, least significant first. It sets the identity only while `initEn` is high and no identity is held yet. Later identity commands leave it unchanged.
- R7: After a read command on a selected device, each prompt presents the next register bit, starting at bit 0. After the top bit, the next prompt wraps back to bit 0.
- R8: After reset, every 8-bit slice of the register holds 8'h60 (bits 6 and 5 set, the rest clear). No identity is held, and `pullLow` is low.
- R9: For a zero bit, the block drives `pullLow` from 1 µs to 5 µs after it detects the prompt's falling edge. For a one bit it never drives. It always releases the line within 13 µs of the prompt.
- R10: An invalid pulse width, a bit after the 4 identity/address bits, or a one during a read aborts the sequence. Nothing is committed, and the block ignores bits until the next marker.
- R11: Committing a register-width word of all ones acts as a software reset. It restores the R8 state, drops the identity and clears selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busIn | input | 1 | Sampled bus line level, 1 = released |
| initEn | input | 1 | Permits this device to accept an identity |
| pullLow | output | 1 | Drives the open-drain line low when 1 |
| ctrlReg | output | 8*SLICES | Control register contents |
| devAddr | output | 4 | Assigned identity |
| addrValid | output | 1 | An identity is held |

## Verification
A mis-tracked framing state shows up at the ports one pulse later: a register value that fails to change, or changes without cause, right after the closing marker, or a read that answers with the wrong bit or not at all. A wrong read index shows on the very next prompt, as a low or released line in the sample window 4 µs after that prompt's falling edge. A bad selection or identity flag shows on the next write or read. For that reason the bench checks the register after every sequence and samples every prompt.

// File: rtl/swbus_pkg.sv
package swbus_pkg;
  typedef enum logic [1:0] {SYM_ZERO, SYM_ONE, SYM_MARK, SYM_BAD} symKind_e;

  // strobes from the framing control into the datapath
  typedef struct packed {
    logic bitVal;
    logic pushData;
    logic clrData;
    logic commit;
    logic pushAddr;
    logic setAddr;
    logic matchAddr;
    logic clrSel;
    logic readStart;
    logic readStep;
    logic readArm;
  } ctrlStb_t;

  localparam logic [7:0] SLICE_RST = 8'h60;
endpackage

// File: rtl/swbus_pulse_meter.sv
module swbus_pulse_meter
  import swbus_pkg::*;
#(
  parameter int CYC_PER_US = 50
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     busIn,
  output logic     fallStb,
  output logic     symValid,
  output symKind_e symKind
);
  localparam int ZMIN    = 1 * CYC_PER_US;
  localparam int ZMAX    = 8 * CYC_PER_US;
  localparam int OMIN    = 24 * CYC_PER_US;
  localparam int OMAX    = 36 * CYC_PER_US;
  localparam int MMIN    = 80 * CYC_PER_US;
  localparam int MMAX    = 120 * CYC_PER_US;
  localparam int CNT_MAX = MMAX + 1;
  localparam int CW      = $clog2(CNT_MAX + 1);

  logic          syncA, syncB, prevLow, lineLow, riseStb;
  logic [CW-1:0] widthCnt;
  symKind_e      kindNow;

  assign lineLow = ~syncB;
  assign fallStb = lineLow & ~prevLow;
  assign riseStb = ~lineLow & prevLow;

  always_comb begin
    if (widthCnt >= CW'(ZMIN) && widthCnt <= CW'(ZMAX))      kindNow = SYM_ZERO;
    else if (widthCnt >= CW'(OMIN) && widthCnt <= CW'(OMAX)) kindNow = SYM_ONE;
    else if (widthCnt >= CW'(MMIN) && widthCnt <= CW'(MMAX)) kindNow = SYM_MARK;
    else                                                     kindNow = SYM_BAD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= 1'b1;
      syncB    <= 1'b1;
      prevLow  <= 1'b0;
      widthCnt <= '0;
      symValid <= 1'b0;
      symKind  <= SYM_BAD;
    end else begin
      syncA    <= busIn;
      syncB    <= syncA;
      prevLow  <= lineLow;
      symValid <= riseStb;
      if (riseStb) symKind <= kindNow;
      if (fallStb) widthCnt <= CW'(1);
      else if (lineLow && widthCnt < CW'(CNT_MAX)) widthCnt <= widthCnt + 1'b1;
    end
  end

  // R1: a symbol is only reported right after the line returned high
  p_sym_after_rise_r1: assert property (@(posedge clk) disable iff (!rstN)
    symValid |-> $past(riseStb));
endmodule

// File: rtl/swbus_ctrl.sv
module swbus_ctrl
  import swbus_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     symValid,
  input  symKind_e symKind,
  input  logic     selected,
  output ctrlStb_t stb
);
  typedef enum logic [2:0] {ST_IDLE, ST_CMD, ST_ADDR, ST_INIT, ST_HOLD, ST_DATA, ST_READ} state_e;

  state_e     state, stateNxt;
  logic [1:0] cmdBits, cmdBitsNxt;
  logic [1:0] bitCnt, bitCntNxt;
  logic       isBit;

  assign isBit = symValid && (symKind == SYM_ZERO || symKind == SYM_ONE);

  always_comb begin
    stb        = '0;
    stb.bitVal = (symKind == SYM_ONE);
    stb.readArm = (state == ST_READ);
    stateNxt   = state;
    cmdBitsNxt = cmdBits;
    bitCntNxt  = bitCnt;
    if (symValid && symKind == SYM_MARK) begin
      stateNxt   = ST_CMD;
      bitCntNxt  = '0;
      stb.commit = (state == ST_DATA);
    end else if (symValid && symKind == SYM_BAD) begin
      stateNxt = ST_IDLE;
    end else if (isBit) begin
      case (state)
        ST_CMD: begin
          if (bitCnt == 2'd2) begin
            bitCntNxt = '0;
            case ({cmdBits, stb.bitVal})
              3'b010: begin stateNxt = ST_ADDR; stb.clrSel = 1'b1; end
              3'b011: stateNxt = ST_INIT;
              3'b001: begin
                stateNxt    = selected ? ST_DATA : ST_IDLE;
                stb.clrData = selected;
              end
              3'b000: begin stateNxt = ST_DATA; stb.clrData = 1'b1; end
              3'b101: begin
                stateNxt      = selected ? ST_READ : ST_IDLE;
                stb.readStart = selected;
              end
              default: stateNxt = ST_IDLE;
            endcase
          end else begin
            cmdBitsNxt = {cmdBits[0], stb.bitVal};
            bitCntNxt  = bitCnt + 1'b1;
          end
        end
        ST_ADDR, ST_INIT: begin
          stb.pushAddr = 1'b1;
          if (bitCnt == 2'd3) begin
            stateNxt      = ST_HOLD;
            stb.matchAddr = (state == ST_ADDR);
            stb.setAddr   = (state == ST_INIT);
          end else begin
            bitCntNxt = bitCnt + 1'b1;
          end
        end
        ST_DATA: stb.pushData = 1'b1;
        ST_READ: begin
          if (symKind == SYM_ZERO) stb.readStep = 1'b1;
          else                     stateNxt = ST_IDLE;
        end
        ST_HOLD: stateNxt = ST_IDLE;
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cmdBits <= '0;
      bitCnt  <= '0;
    end else begin
      state   <= stateNxt;
      cmdBits <= cmdBitsNxt;
      bitCnt  <= bitCntNxt;
    end
  end

  // R10: after an invalid width the framing always falls back to idle
  p_bad_aborts_r10: assert property (@(posedge clk) disable iff (!rstN)
    (symValid && symKind == SYM_BAD) |=> (state == ST_IDLE));
endmodule

// File: rtl/swbus_datapath.sv
module swbus_datapath
  import swbus_pkg::*;
#(
  parameter int SLICES     = 1,
  parameter int CYC_PER_US = 50
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStb_t              stb,
  input  logic                  fallStb,
  input  logic                  initEn,
  output logic [8*SLICES-1:0]   ctrlReg,
  output logic [3:0]            devAddr,
  output logic                  addrValid,
  output logic                  selected,
  output logic                  pullLow
);
  localparam int W        = 8 * SLICES;
  localparam int IDX_W    = $clog2(W);
  localparam int DCW      = $clog2(W + 1);
  localparam int DRV_ON   = CYC_PER_US;
  localparam int DRV_OFF  = 5 * CYC_PER_US;
  localparam int TW       = $clog2(DRV_OFF + 1);
  localparam int CK_MAX   = 13 * CYC_PER_US;
  localparam int CKW      = $clog2(CK_MAX + 1);
  localparam int DEADLINE = CK_MAX - 3;
  localparam logic [W-1:0] RST_VAL = {SLICES{SLICE_RST}};

  logic [W-1:0]     dataSh;
  logic [DCW-1:0]   dataCnt;
  logic [3:0]       addrSh, addrNxt;
  logic [IDX_W-1:0] readIdx;
  logic [TW-1:0]    drvTmr;
  logic             drvOn;
  logic [CKW-1:0]   sinceFall;

  assign addrNxt = {stb.bitVal, addrSh[3:1]};
  assign pullLow = drvOn && (drvTmr >= TW'(DRV_ON));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= RST_VAL;
      dataSh    <= '0;
      dataCnt   <= '0;
      addrSh    <= '0;
      devAddr   <= '0;
      addrValid <= 1'b0;
      selected  <= 1'b0;
      readIdx   <= '0;
      drvOn     <= 1'b0;
      drvTmr    <= '0;
    end else begin
      if (stb.clrData) dataCnt <= '0;
      else if (stb.pushData) begin
        dataSh <= {stb.bitVal, dataSh[W-1:1]};
        if (dataCnt < DCW'(W)) dataCnt <= dataCnt + 1'b1;
      end
      if (stb.pushAddr) addrSh <= addrNxt;
      if (stb.setAddr && initEn && !addrValid) begin
        devAddr   <= addrNxt;
        addrValid <= 1'b1;
      end
      if (stb.clrSel) selected <= 1'b0;
      if (stb.matchAddr) selected <= addrValid && (addrNxt == devAddr);
      if (stb.readStart) readIdx <= '0;
      else if (stb.readStep) readIdx <= (readIdx == IDX_W'(W - 1)) ? '0 : readIdx + 1'b1;
      // prompt answer: hold the line only for a zero bit
      if (fallStb && stb.readArm && !ctrlReg[readIdx]) begin
        drvOn  <= 1'b1;
        drvTmr <= '0;
      end else if (!stb.readArm || (drvOn && drvTmr == TW'(DRV_OFF - 1))) begin
        drvOn <= 1'b0;
      end else if (drvOn) begin
        drvTmr <= drvTmr + 1'b1;
      end
      if (stb.commit && dataCnt == DCW'(W)) begin
        if (&dataSh) begin
          ctrlReg   <= RST_VAL;
          devAddr   <= '0;
          addrValid <= 1'b0;
          selected  <= 1'b0;
        end else begin
          ctrlReg <= dataSh;
        end
      end
    end
  end

  // cycles since the last detected prompt edge, for the release check
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceFall <= CKW'(CK_MAX);
    else if (fallStb) sinceFall <= '0;
    else if (sinceFall < CKW'(CK_MAX)) sinceFall <= sinceFall + 1'b1;
  end

  // R4: the register only moves right after a commit strobe
  p_reg_on_commit_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctrlReg) |-> $past(stb.commit));
  // R6: a held identity never changes
  p_addr_once_r6: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && $past(addrValid)) |-> $stable(devAddr));
  // R9: the line is only pulled while a read was open
  p_pull_in_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    pullLow |-> $past(stb.readArm));
  // R9: the line is released well before the deadline after a prompt
  p_release_deadline_r9: assert property (@(posedge clk) disable iff (!rstN)
    pullLow |-> (sinceFall < CKW'(DEADLINE)));
endmodule

// File: rtl/swbus_slave.sv
module swbus_slave
  import swbus_pkg::*;
#(
  parameter int SLICES     = 1,
  parameter int CYC_PER_US = 50
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busIn,
  input  logic                initEn,
  output logic                pullLow,
  output logic [8*SLICES-1:0] ctrlReg,
  output logic [3:0]          devAddr,
  output logic                addrValid
);
  logic     fallStb, symValid, selected;
  symKind_e symKind;
  ctrlStb_t stb;

  swbus_pulse_meter #(.CYC_PER_US(CYC_PER_US)) meter_i (
    .clk(clk), .rstN(rstN), .busIn(busIn),
    .fallStb(fallStb), .symValid(symValid), .symKind(symKind));

  swbus_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .symValid(symValid), .symKind(symKind),
    .selected(selected), .stb(stb));

  swbus_datapath #(.SLICES(SLICES), .CYC_PER_US(CYC_PER_US)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .fallStb(fallStb), .initEn(initEn),
    .ctrlReg(ctrlReg), .devAddr(devAddr), .addrValid(addrValid),
    .selected(selected), .pullLow(pullLow));
endmodule

// File: tb/swbus_slave_tb.sv
module swbus_slave_tb_top;
  localparam int C = 2;       // cycles per microsecond, scaled for a short run
  localparam int SL = 2;
  localparam int W = 8 * SL;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostLow = 1'b0;
  logic initEn = 1'b0;
  logic pullLow, addrValid, busIn;
  logic [W-1:0] ctrlReg;
  logic [3:0] devAddr;

  int checks = 0;
  int failures = 0;
  int zUs = 5;
  int oUs = 30;
  logic sampleReq = 1'b0;
  logic expQ[$];
  string reqQ[$];

  always #5 clk = ~clk;
  assign busIn = ~(hostLow | pullLow);

  swbus_slave #(.SLICES(SL), .CYC_PER_US(C)) dut_i (
    .clk(clk), .rstN(rstN), .busIn(busIn), .initEn(initEn), .pullLow(pullLow),
    .ctrlReg(ctrlReg), .devAddr(devAddr), .addrValid(addrValid));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compares the line level in each prompt sample window
  always @(negedge clk) begin
    if (sampleReq && expQ.size() > 0) begin
      logic e;
      string r;
      e = expQ.pop_front();
      r = reqQ.pop_front();
      check(busIn === e, r, {31'd0, busIn}, {31'd0, e});
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(input int us);
    hostLow = 1'b1;
    waitCyc(us * C);
    hostLow = 1'b0;
    waitCyc(10 * C);
  endtask

  task automatic sendBit(input logic b);
    pulse(b ? oUs : zUs);
  endtask

  task automatic sendCmd(input logic [2:0] code);
    pulse(100);
    for (int i = 2; i >= 0; i--) sendBit(code[i]);
  endtask

  task automatic endSeq();
    sendCmd(3'b111);
  endtask

  task automatic idSeq(input logic [2:0] code, input logic [3:0] a);
    sendCmd(code);
    for (int i = 0; i < 4; i++) sendBit(a[i]);
    endSeq();
  endtask

  task automatic dataSeq(input logic [2:0] code, input logic [31:0] d, input int n);
    sendCmd(code);
    for (int i = 0; i < n; i++) sendBit(d[i]);
    endSeq();
  endtask

  // driver: one prompt, expected level pushed for the monitor
  task automatic prompt(input logic e, input string req);
    expQ.push_back(e);
    reqQ.push_back(req);
    hostLow = 1'b1;
    waitCyc(3 * C);
    hostLow = 1'b0;
    waitCyc(1 * C);
    sampleReq = 1'b1;
    waitCyc(1);
    sampleReq = 1'b0;
    waitCyc(10 * C);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    waitCyc(4);
    rstN = 1'b1;
    waitCyc(4);
    // R8 reset state
    check(ctrlReg == 16'h6060, "R8 reset value", ctrlReg, 16'h6060);
    check(addrValid == 1'b0, "R8 no identity", addrValid, 0);
    check(pullLow == 1'b0, "R8 line released", pullLow, 0);

    // R5 R2 broadcast without address
    dataSeq(3'b000, 32'hA5C3, 16);
    check(ctrlReg == 16'hA5C3, "R5 broadcast load", ctrlReg, 16'hA5C3);

    // R4 extra bits: last 16 kept
    dataSeq(3'b000, 32'hBEEF7, 20);
    check(ctrlReg == 16'hBEEF, "R4 last bits kept", ctrlReg, 16'hBEEF);

    // R4 too few bits
    dataSeq(3'b000, 32'h3FF, 10);
    check(ctrlReg == 16'hBEEF, "R4 short write ignored", ctrlReg, 16'hBEEF);

    // R3 write while not selected
    dataSeq(3'b001, 32'h1111, 16);
    check(ctrlReg == 16'hBEEF, "R3 unselected write", ctrlReg, 16'hBEEF);

    // R6 identity assignment, then a second attempt
    initEn = 1'b1;
    idSeq(3'b011, 4'hA);
    check(addrValid && devAddr == 4'hA, "R6 identity set", {27'd0, addrValid, devAddr}, 32'h1A);
    idSeq(3'b011, 4'h5);
    check(devAddr == 4'hA, "R6 identity kept", devAddr, 4'hA);

    // R3 mismatch then match
    idSeq(3'b010, 4'h5);
    dataSeq(3'b001, 32'h2222, 16);
    check(ctrlReg == 16'hBEEF, "R3 mismatched address", ctrlReg, 16'hBEEF);
    idSeq(3'b010, 4'hA);
    dataSeq(3'b001, 32'h3C5A, 16);
    check(ctrlReg == 16'h3C5A, "R3 matched write", ctrlReg, 16'h3C5A);

    // R7 R9 readback with wrap
    sendCmd(3'b101);
    for (int i = 0; i < 20; i++) begin
      logic [15:0] v;
      v = 16'h3C5A;
      prompt(v[i % 16], "R7 R9 read bit");
    end
    endSeq();

    // R10 invalid width mid write
    sendCmd(3'b001);
    for (int i = 0; i < 8; i++) sendBit(1'b0);
    pulse(15);
    for (int i = 0; i < 8; i++) sendBit(1'b1);
    endSeq();
    check(ctrlReg == 16'h3C5A, "R10 aborted write", ctrlReg, 16'h3C5A);

    // R10 a one during read closes it: prompts go unanswered
    sendCmd(3'b101);
    sendBit(1'b1);
    for (int i = 0; i < 3; i++) prompt(1'b1, "R10 read aborted");
    endSeq();

    // R1 widths near the range edges
    zUs = 7;
    oUs = 34;
    dataSeq(3'b000, 32'h0F0F, 16);
    check(ctrlReg == 16'h0F0F, "R1 edge widths", ctrlReg, 16'h0F0F);
    zUs = 5;
    oUs = 26;
    dataSeq(3'b000, 32'h00F1, 16);
    check(ctrlReg == 16'h00F1, "R1 low one width", ctrlReg, 16'h00F1);
    oUs = 30;

    // R11 all ones resets
    dataSeq(3'b000, 32'hFFFF, 16);
    check(ctrlReg == 16'h6060, "R11 reset value", ctrlReg, 16'h6060);
    check(addrValid == 1'b0, "R11 identity dropped", addrValid, 0);
    sendCmd(3'b101);
    for (int i = 0; i < 3; i++) prompt(1'b1, "R11 deselected read");
    endSeq();

    // R6 enable gating after reset
    initEn = 1'b0;
    idSeq(3'b011, 4'h3);
    check(addrValid == 1'b0, "R6 identity blocked", addrValid, 0);
    initEn = 1'b1;
    idSeq(3'b011, 4'h3);
    check(addrValid && devAddr == 4'h3, "R6 identity after reset", {27'd0, addrValid, devAddr}, 32'h13);
    check(pullLow == 1'b0, "R9 idle released", pullLow, 0);

    waitCyc(10);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule